// File: doc/BRIEF.md
# Overlapped Internal Memory Steering Unit

This block sits between an 8-bit microcontroller core and its internal memories. It contains the 256-byte on-chip data RAM and routes every data access from the core to one of two targets. The lower half of the internal data space, 00h to 7Fh, is always RAM. The upper half, 80h to FFh, holds two separate stores at the same addresses: the upper RAM half and the special function register (SFR) bus. The addressing mode of each access picks the store. Direct accesses go to the SFR bus. Indirect accesses go to RAM, and that includes stack pushes and pops.

The block also steers instruction fetches. A 16-bit fetch address goes to the internal program memory port or to the external program memory port, based on a strap input. With the strap low, every fetch goes to the external port. With the strap high, the lowest 8K bytes (0000h to 1FFFh) are internal and the rest (2000h to FFFFh) are external.

Data reads return one cycle after the read strobe. The data comes from whichever target was selected on that strobe. The fetch path is purely combinational.

Top module: `mem_steer_top`

## Requirements
- R1: An access to 00h–7Fh reaches RAM in either mode and never raises `sfr_rd` or `sfr_wr`.
- R2: A direct access (`cpu_indirect`=0) to 80h–FFh raises `sfr_rd` or `sfr_wr` in the same cycle as the CPU strobe, with `sfr_addr` equal to `cpu_addr` and `sfr_wdata` equal to `cpu_wdata`.
- R3: A direct write to 80h–FFh leaves the RAM byte at that address unchanged.
- R4: An indirect access (`cpu_indirect`=1) to 80h–FFh reaches the upper RAM half and never raises `sfr_rd` or `sfr_wr`.
- R5: `cpu_rdata` changes only on the clock edge that samples `cpu_rd` high. It then shows the RAM byte or the `sfr_rdata` value captured at that edge, whichever target was selected. It holds that value until the next read.
- R6: With `ea_strap` low, every fetch raises `xmem_req` with `xmem_addr`=`fetch_addr`, and `fetch_data` follows `xmem_rdata`.
- R7: With `ea_strap` high and `fetch_addr` below 2000h, a fetch raises `imem_req` with `imem_addr` equal to the low 13 bits of the address, and `fetch_data` follows `imem_rdata`.
- R8: With `ea_strap` high and `fetch_addr` at 2000h or above, a fetch goes to the external port.
- R9: After synchronous reset `cpu_rdata` reads 00h.
- R10: With `fetch_req` low, neither `imem_req` nor `xmem_req` is asserted, and the two are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 8 | Internal data address |
| cpu_wdata | input | 8 | Write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_indirect | input | 1 | 1 = indirect/stack access, 0 = direct |
| cpu_rdata | output | 8 | Read data, one cycle after read |
| sfr_addr | output | 8 | SFR address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rd | output | 1 | SFR read strobe |
| sfr_wr | output | 1 | SFR write strobe |
| sfr_rdata | input | 8 | SFR read data |
| ea_strap | input | 1 | External-access strap |
| fetch_req | input | 1 | Instruction fetch request |
| fetch_addr | input | 16 | Fetch address |
| fetch_data | output | 8 | Fetched byte |
| imem_req | output | 1 | Internal program memory request |
| imem_addr | output | 13 | Internal program memory address |
| imem_rdata | input | 8 | Internal program memory data |
| xmem_req | output | 1 | External program memory request |
| xmem_addr | output | 16 | External program memory address |
| xmem_rdata | input | 8 | External program memory data |

## Verification
The captured read-target select can be wrong, for example when it points at the SFR capture after an indirect upper-half read. The port then shows the SFR value instead of the RAM byte on the very next cycle after the read. A RAM write-enable that leaks on direct upper writes corrupts the stored byte without any immediate sign. The damage shows only when a later indirect read of the same address returns the SFR write data. The bench therefore pairs every direct write with an indirect read-back. Fetch steering errors show up in the same cycle as wrong request lines or a wrong data source, at the 1FFFh/2000h boundary and for both strap values.

// File: rtl/mem_steer_pkg.sv
package mem_steer_pkg;

    localparam int DATA_AW     = 8;
    localparam int DATA_W      = 8;
    localparam int PROG_AW     = 16;
    localparam int INT_PROG_AW = 13;

    typedef enum logic {
        TGT_RAM = 1'b0,
        TGT_SFR = 1'b1
    } data_tgt_e;

    typedef enum logic {
        FT_INT = 1'b0,
        FT_EXT = 1'b1
    } fetch_tgt_e;

    typedef struct packed {
        data_tgt_e tgt;
        logic      ram_we;
        logic      ram_re;
        logic      sfr_we;
        logic      sfr_re;
    } data_route_t;

    typedef struct packed {
        logic       active;
        fetch_tgt_e tgt;
    } fetch_route_t;

    // Upper half plus direct mode selects the register bus.
    function automatic data_tgt_e pick_data_tgt(input logic upper, input logic indirect);
        return (upper && !indirect) ? TGT_SFR : TGT_RAM;
    endfunction

    function automatic fetch_tgt_e pick_fetch_tgt(input logic strap, input logic in_low_window);
        return (strap && in_low_window) ? FT_INT : FT_EXT;
    endfunction

endpackage

// File: rtl/mem_steer_data_dec.sv
module mem_steer_data_dec
    import mem_steer_pkg::*;
#(
    parameter int AW = DATA_AW
) (
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    input  logic          indirect,
    output data_route_t   route
);
    logic upper;
    assign upper = addr[AW-1];

    always_comb begin
        route.tgt    = pick_data_tgt(upper, indirect);
        route.ram_we = wr && (route.tgt == TGT_RAM);
        route.ram_re = rd && (route.tgt == TGT_RAM);
        route.sfr_we = wr && (route.tgt == TGT_SFR);
        route.sfr_re = rd && (route.tgt == TGT_SFR);
    end
endmodule

// File: rtl/mem_steer_ram.sv
module mem_steer_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          we,
    input  logic          re,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= store[addr];
    end
endmodule

// File: rtl/mem_steer_fetch.sv
module mem_steer_fetch
    import mem_steer_pkg::*;
#(
    parameter int PAW = PROG_AW,
    parameter int IAW = INT_PROG_AW,
    parameter int DW  = DATA_W
) (
    input  logic           strap,
    input  logic           req,
    input  logic [PAW-1:0] addr,
    input  logic [DW-1:0]  int_rdata,
    input  logic [DW-1:0]  ext_rdata,
    output logic           int_req,
    output logic [IAW-1:0] int_addr,
    output logic           ext_req,
    output logic [PAW-1:0] ext_addr,
    output logic [DW-1:0]  rdata
);
    fetch_route_t fr;
    logic         low_window;

    // Address lies in the internal window when all bits above IAW are zero.
    assign low_window = (addr[PAW-1:IAW] == '0);

    always_comb begin
        fr.active = req;
        fr.tgt    = pick_fetch_tgt(strap, low_window);
    end

    assign int_req  = fr.active && (fr.tgt == FT_INT);
    assign ext_req  = fr.active && (fr.tgt == FT_EXT);
    assign int_addr = addr[IAW-1:0];
    assign ext_addr = addr;
    assign rdata    = (fr.tgt == FT_INT) ? int_rdata : ext_rdata;
endmodule

// File: rtl/mem_steer_top.sv
module mem_steer_top
    import mem_steer_pkg::*;
#(
    parameter int AW  = DATA_AW,
    parameter int DW  = DATA_W,
    parameter int PAW = PROG_AW,
    parameter int IAW = INT_PROG_AW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  cpu_addr,
    input  logic [DW-1:0]  cpu_wdata,
    input  logic           cpu_rd,
    input  logic           cpu_wr,
    input  logic           cpu_indirect,
    output logic [DW-1:0]  cpu_rdata,
    output logic [AW-1:0]  sfr_addr,
    output logic [DW-1:0]  sfr_wdata,
    output logic           sfr_rd,
    output logic           sfr_wr,
    input  logic [DW-1:0]  sfr_rdata,
    input  logic           ea_strap,
    input  logic           fetch_req,
    input  logic [PAW-1:0] fetch_addr,
    output logic [DW-1:0]  fetch_data,
    output logic           imem_req,
    output logic [IAW-1:0] imem_addr,
    input  logic [DW-1:0]  imem_rdata,
    output logic           xmem_req,
    output logic [PAW-1:0] xmem_addr,
    input  logic [DW-1:0]  xmem_rdata
);
    data_route_t   route;
    logic [DW-1:0] ram_q;
    logic [DW-1:0] sfr_q;
    data_tgt_e     sel_q;

    mem_steer_data_dec #(.AW(AW)) u_dec (
        .addr     (cpu_addr),
        .rd       (cpu_rd),
        .wr       (cpu_wr),
        .indirect (cpu_indirect),
        .route    (route)
    );

    mem_steer_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .addr  (cpu_addr),
        .wdata (cpu_wdata),
        .we    (route.ram_we),
        .re    (route.ram_re),
        .rdata (ram_q)
    );

    assign sfr_addr  = cpu_addr;
    assign sfr_wdata = cpu_wdata;
    assign sfr_rd    = route.sfr_re;
    assign sfr_wr    = route.sfr_we;

    // Capture the register bus data and the target on the read edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            sfr_q <= '0;
            sel_q <= TGT_RAM;
        end else if (cpu_rd) begin
            sel_q <= route.tgt;
            if (route.sfr_re) sfr_q <= sfr_rdata;
        end
    end

    assign cpu_rdata = (sel_q == TGT_SFR) ? sfr_q : ram_q;

    mem_steer_fetch #(.PAW(PAW), .IAW(IAW), .DW(DW)) u_fetch (
        .strap     (ea_strap),
        .req       (fetch_req),
        .addr      (fetch_addr),
        .int_rdata (imem_rdata),
        .ext_rdata (xmem_rdata),
        .int_req   (imem_req),
        .int_addr  (imem_addr),
        .ext_req   (xmem_req),
        .ext_addr  (xmem_addr),
        .rdata     (fetch_data)
    );

    AST_LOW_NO_SFR: assert property (@(posedge clk) disable iff (rst)
        !cpu_addr[AW-1] |-> (!sfr_rd && !sfr_wr)); // R1
    AST_DIRECT_UPPER_SFR: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[AW-1] && !cpu_indirect && cpu_wr) |-> sfr_wr); // R2
    AST_DIRECT_WR_NO_RAM: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[AW-1] && !cpu_indirect) |-> !route.ram_we); // R3
    AST_INDIRECT_NO_SFR: assert property (@(posedge clk) disable iff (rst)
        cpu_indirect |-> (!sfr_rd && !sfr_wr)); // R4
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(cpu_rd) |-> $stable(cpu_rdata)); // R5
    AST_STRAP_LOW_EXT: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !ea_strap) |-> (xmem_req && xmem_addr == fetch_addr)); // R6
    AST_INT_WINDOW: assert property (@(posedge clk) disable iff (rst)
        imem_req |-> (ea_strap && fetch_addr < PAW'(1 << IAW))); // R7
    AST_UPPER_PROG_EXT: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && fetch_addr >= PAW'(1 << IAW)) |-> xmem_req); // R8
    AST_FETCH_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({imem_req, xmem_req}) && (fetch_req || (!imem_req && !xmem_req))); // R10
endmodule

// File: tb/mem_steer_top_tb.sv
module mem_steer_top_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  cpu_addr, cpu_wdata, cpu_rdata;
    logic        cpu_rd, cpu_wr, cpu_indirect;
    logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;
    logic        sfr_rd, sfr_wr;
    logic        ea_strap, fetch_req;
    logic [15:0] fetch_addr, xmem_addr;
    logic [7:0]  fetch_data, imem_rdata, xmem_rdata;
    logic        imem_req, xmem_req;
    logic [12:0] imem_addr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_steer_top dut_i (.*);

    // {strap, addr, expect_internal}
    typedef struct packed {
        logic        strap;
        logic [15:0] addr;
        logic        exp_int;
    } fvec_t;

    localparam fvec_t FVECS [8] = '{
        '{1'b0, 16'h0000, 1'b0},   // R6
        '{1'b0, 16'h1FFF, 1'b0},   // R6
        '{1'b0, 16'hFFFF, 1'b0},   // R6
        '{1'b1, 16'h0000, 1'b1},   // R7
        '{1'b1, 16'h0ABC, 1'b1},   // R7
        '{1'b1, 16'h1FFF, 1'b1},   // R7
        '{1'b1, 16'h2000, 1'b0},   // R8
        '{1'b1, 16'hFFFF, 1'b0}    // R8
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        cpu_rd = 0; cpu_wr = 0;
    endtask

    // Drive a write at negedge; check strobes mid-cycle; commits at posedge.
    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic ind,
                            input logic exp_sfr, input string req);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_indirect = ind; cpu_wr = 1; cpu_rd = 0;
        #1;
        chk(req, {sfr_wr, sfr_rd}, {exp_sfr, 1'b0});
        if (exp_sfr) begin
            chk(req, sfr_addr, a);
            chk(req, sfr_wdata, d);
        end
        @(negedge clk);
        idle();
    endtask

    task automatic do_read(input logic [7:0] a, input logic ind, input logic exp_sfr,
                           input logic [7:0] exp, input string req);
        @(negedge clk);
        cpu_addr = a; cpu_indirect = ind; cpu_rd = 1; cpu_wr = 0;
        #1;
        chk(req, {sfr_rd, sfr_wr}, {exp_sfr, 1'b0});
        @(negedge clk);
        idle();
        chk(req, cpu_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1; idle(); cpu_addr = 0; cpu_wdata = 0; cpu_indirect = 0;
        sfr_rdata = 8'h77; ea_strap = 0; fetch_req = 0; fetch_addr = 0;
        imem_rdata = 8'hA5; xmem_rdata = 8'h3C;
        repeat (4) @(negedge clk);
        chk("R9", cpu_rdata, 8'h00);
        rst = 0;

        // Fetch table walk
        foreach (FVECS[i]) begin
            @(negedge clk);
            ea_strap = FVECS[i].strap; fetch_addr = FVECS[i].addr; fetch_req = 1;
            #1;
            if (FVECS[i].exp_int) begin
                chk("R7", {imem_req, xmem_req}, 2'b10);
                chk("R7", imem_addr, FVECS[i].addr[12:0]);
                chk("R7", fetch_data, 8'hA5);
            end else begin
                chk(FVECS[i].strap ? "R8" : "R6", {imem_req, xmem_req}, 2'b01);
                chk(FVECS[i].strap ? "R8" : "R6", xmem_addr, FVECS[i].addr);
                chk(FVECS[i].strap ? "R8" : "R6", fetch_data, 8'h3C);
            end
        end
        @(negedge clk);
        fetch_req = 0; ea_strap = 1; fetch_addr = 16'h0010;
        #1 chk("R10", {imem_req, xmem_req}, 2'b00);

        // Lower half in both modes
        do_write(8'h20, 8'h11, 1'b1, 1'b0, "R1");
        do_read (8'h20, 1'b0, 1'b0, 8'h11, "R1");
        do_write(8'h7F, 8'h22, 1'b0, 1'b0, "R1");
        do_read (8'h7F, 1'b1, 1'b0, 8'h22, "R1");

        // Upper half overlap
        do_write(8'hA0, 8'h5A, 1'b1, 1'b0, "R4");
        do_write(8'hA0, 8'hC3, 1'b0, 1'b1, "R2");
        do_read (8'hA0, 1'b1, 1'b0, 8'h5A, "R3");
        do_read (8'hA0, 1'b0, 1'b1, 8'h77, "R2");
        do_write(8'h80, 8'h01, 1'b1, 1'b0, "R4");
        do_write(8'h80, 8'hFE, 1'b0, 1'b1, "R3");
        do_read (8'h80, 1'b1, 1'b0, 8'h01, "R3");

        // Stack top byte
        do_write(8'hFF, 8'h9D, 1'b1, 1'b0, "R4");
        do_read (8'hFF, 1'b1, 1'b0, 8'h9D, "R4");

        // Hold after read while SFR data and address move
        do_read (8'hC0, 1'b0, 1'b1, 8'h77, "R5");
        sfr_rdata = 8'h44; cpu_addr = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R5", cpu_rdata, 8'h77);
        do_write(8'h20, 8'hEE, 1'b1, 1'b0, "R5");
        chk("R5", cpu_rdata, 8'h77);
        do_read (8'hC0, 1'b0, 1'b1, 8'h44, "R5");
        do_read (8'h20, 1'b1, 1'b0, 8'hEE, "R5");

        // Reset again clears read data
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        chk("R9", cpu_rdata, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule